// File: doc/BRIEF.md
# Asynchronous SRAM byte-lane controller

This block lets synchronous logic use an external asynchronous 64K x 16 static RAM. A request port with a valid/ready handshake takes one access at a time. Each access carries a read/write flag, a word address, write data and one enable bit per byte lane. The controller drives the memory's address bus, chip select, output enable, write enable and a per-lane byte strobe, all from flip-flops. The data bus is split into an output word, an output-enable flag and an input word, so the pad logic can be placed outside the block.

Every access is stretched over a whole number of clock cycles. The counts come from the memory's nanosecond limits and the clock period: each count is the ceiling of the limit divided by the period, and never less than one cycle. Reads sample the bus on the last cycle of the access and return the word with a one-cycle valid pulse. After each access the block waits out a turnaround gap before it accepts the next request. After a read, that gap covers the memory's float time. After a write, it covers the low-impedance recovery time, so the two sides never drive the bus at once.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, req_ready is 1, mem_cs_n, mem_oe_n and mem_we_n are 1, every bit of mem_bs_n is 1, mem_dq_oe is 0 and rsp_valid is 0.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. req_ready is 0 from the next cycle until the turnaround gap of that access has ended.
- R3: A read holds mem_cs_n=0, mem_oe_n=0, mem_we_n=1 and a steady mem_addr for RD_CYC cycles. RD_CYC is the larger of the cycle counts for read-cycle time and address access time, which is 11 at the defaults with a 5 ns clock.
- R4: Read data is sampled at the edge that ends the read window. The cycle after that edge, rsp_valid is 1 for exactly one cycle with rsp_rdata.
- R5: A write holds mem_cs_n=0, mem_we_n=0, mem_oe_n=1 and mem_dq_oe=1, with the address and data steady, for WR_CYC cycles. WR_CYC is the largest of the cycle counts for write pulse, address-to-write-end and data setup, which is 9 at the defaults.
- R6: In the cycle after mem_we_n returns to 1, mem_addr and mem_dq_out stay unchanged and mem_dq_oe stays 1. Chip select and all strobes are already 1.
- R7: Lane i of the bus is bits 8i+7:8i. mem_bs_n[i] is 0 during an access exactly when req_be[i] was 1, so a write leaves the disabled lanes of the stored word unchanged.
- R8: After a read, req_ready returns only after HZ_CYC cycles with output enable released (4 at the defaults). mem_dq_oe is never 1 while mem_oe_n is 0.
- R9: After a write, mem_dq_oe drops one cycle after the hold cycle. req_ready returns TW_CYC cycles later (1 at the defaults), so from acceptance to ready is WR_CYC+1+TW_CYC cycles.
- R10: If a lane's enable bit is 0 in a read, that lane of rsp_rdata is 0. A request with both enable bits 0 asserts no strobe and reads back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Per-lane enable, bit 0 = bits 7:0 |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | DATA_W | Read data, disabled lanes zero |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bs_n | output | DATA_W/8 | Byte strobes, active low, bit 0 = lower lane |
| mem_dq_out | output | DATA_W | Data to drive onto the bus |
| mem_dq_oe | output | 1 | 1 = controller drives the bus |
| mem_dq_in | input | DATA_W | Data read from the bus |

## Verification
The bench's memory model returns valid data only after the full access window has passed. A controller that samples one cycle early therefore reads a junk pattern instead of the stored word. The model flags any cycle in which the controller drives the bus while the memory has its outputs enabled, so a turnaround gap that is too short after a read, or a read that starts too soon after a write, is caught. Byte-masked writes are read back as whole words, so a wrong strobe shows up as a changed byte in a lane that should have been left alone. Cycle counts from acceptance to ready are compared exactly, so an extra or missing wait cycle is reported.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACC,
    ST_HOLD,
    ST_TURN
  } seq_state_t;

  // Ceiling of a nanosecond limit over the clock period (in ps), at least 1.
  function automatic int ns_to_cyc(input int ns, input int clk_ps);
    int c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_access_seq.sv
module sram_access_seq
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LANES  = 2,
  parameter int RD_CYC = 11,
  parameter int WR_CYC = 9,
  parameter int HZ_CYC = 4,
  parameter int TW_CYC = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [LANES-1:0]  req_be,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [LANES-1:0]  lane_act,
  output logic              dq_drive,
  output logic [DATA_W-1:0] dq_out,
  output logic              cap_en,
  output logic [LANES-1:0]  cap_be
);

  localparam int MAXC  = max2(max2(RD_CYC, WR_CYC), max2(HZ_CYC, TW_CYC));
  localparam int CNT_W = $clog2(MAXC + 1);

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic             is_wr;
  logic [LANES-1:0] be_q;
  logic             accept;

  assign accept = req_valid && req_ready;
  assign cap_en = (state == ST_ACC) && !is_wr && (cnt == '0);
  assign cap_be = be_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      is_wr     <= 1'b0;
      be_q      <= '0;
      req_ready <= 1'b1;
      mem_addr  <= '0;
      mem_cs_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      lane_act  <= '0;
      dq_drive  <= 1'b0;
      dq_out    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state     <= ST_ACC;
            is_wr     <= req_write;
            be_q      <= req_be;
            req_ready <= 1'b0;
            mem_addr  <= req_addr;
            mem_cs_n  <= 1'b0;
            mem_oe_n  <= req_write;
            mem_we_n  <= !req_write;
            lane_act  <= req_be;
            dq_drive  <= req_write;
            dq_out    <= req_wdata;
            cnt       <= req_write ? CNT_W'(WR_CYC - 1) : CNT_W'(RD_CYC - 1);
          end
        end
        ST_ACC: begin
          if (cnt == '0) begin
            mem_cs_n <= 1'b1;
            mem_oe_n <= 1'b1;
            mem_we_n <= 1'b1;
            lane_act <= '0;
            if (is_wr) begin
              state <= ST_HOLD;
            end else begin
              state <= ST_TURN;
              cnt   <= CNT_W'(HZ_CYC - 1);
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_HOLD: begin
          dq_drive <= 1'b0;
          state    <= ST_TURN;
          cnt      <= CNT_W'(TW_CYC - 1);
        end
        ST_TURN: begin
          if (cnt == '0) begin
            state     <= ST_IDLE;
            req_ready <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Checker counters: cycles with write enable low, and quiet cycles since
  // the controller or the memory last had the bus.
  logic [7:0] we_low;
  logic [7:0] quiet_drv;
  logic [7:0] quiet_oe;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_low    <= '0;
      quiet_drv <= 8'hFF;
      quiet_oe  <= 8'hFF;
    end else begin
      we_low    <= !mem_we_n ? we_low + 1'b1 : '0;
      quiet_drv <= dq_drive ? '0 : ((quiet_drv == 8'hFF) ? quiet_drv : quiet_drv + 1'b1);
      quiet_oe  <= !mem_oe_n ? '0 : ((quiet_oe == 8'hFF) ? quiet_oe : quiet_oe + 1'b1);
    end
  end

  a_r2_ready_only_idle: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_cs_n && mem_oe_n && mem_we_n && !dq_drive));

  a_r3_addr_steady: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

  a_r5_pulse_len: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_low == 8'(WR_CYC)));

  a_r6_hold_after_we: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (dq_drive && $stable(mem_addr) && $stable(dq_out)));

  a_r8_no_drive_while_oe: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !dq_drive);

  a_r8_drive_after_float: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_drive) |-> (quiet_oe >= 8'(HZ_CYC)));

  a_r9_oe_after_release: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_oe_n) |-> (quiet_drv >= 8'(TW_CYC)));

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic [LANES-1:0]  cap_be,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  localparam int LW = DATA_W / LANES;

  logic [DATA_W-1:0] masked;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign masked[i*LW +: LW] = cap_be[i] ? dq_in[i*LW +: LW] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= cap_en;
      if (cap_en) rd_data <= masked;
    end
  end

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int CLK_PS  = 5000,
  parameter int T_RC_NS = 55,
  parameter int T_AA_NS = 55,
  parameter int T_WC_NS = 55,
  parameter int T_WP_NS = 40,
  parameter int T_AW_NS = 45,
  parameter int T_DW_NS = 25,
  parameter int T_HZ_NS = 20,
  parameter int T_OW_NS = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [DATA_W/8-1:0]   req_be,
  output logic                  rsp_valid,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic                  mem_cs_n,
  output logic                  mem_oe_n,
  output logic                  mem_we_n,
  output logic [DATA_W/8-1:0]   mem_bs_n,
  output logic [DATA_W-1:0]     mem_dq_out,
  output logic                  mem_dq_oe,
  input  logic [DATA_W-1:0]     mem_dq_in
);

  localparam int LANES  = DATA_W / 8;
  localparam int RD_CYC = max2(ns_to_cyc(T_AA_NS, CLK_PS), ns_to_cyc(T_RC_NS, CLK_PS));
  localparam int WR_CYC = max2(ns_to_cyc(T_WP_NS, CLK_PS),
                               max2(ns_to_cyc(T_AW_NS, CLK_PS), ns_to_cyc(T_DW_NS, CLK_PS)));
  localparam int HZ_CYC = ns_to_cyc(T_HZ_NS, CLK_PS);
  localparam int WC_GAP = ns_to_cyc(T_WC_NS, CLK_PS) - WR_CYC - 1;
  localparam int TW_CYC = max2(ns_to_cyc(T_OW_NS, CLK_PS), WC_GAP);

  logic [LANES-1:0] lane_act;
  logic             cap_en;
  logic [LANES-1:0] cap_be;

  sram_access_seq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LANES  (LANES),
    .RD_CYC (RD_CYC),
    .WR_CYC (WR_CYC),
    .HZ_CYC (HZ_CYC),
    .TW_CYC (TW_CYC)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_be    (req_be),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_ready (req_ready),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .lane_act  (lane_act),
    .dq_drive  (mem_dq_oe),
    .dq_out    (mem_dq_out),
    .cap_en    (cap_en),
    .cap_be    (cap_be)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_strobe
    assign mem_bs_n[i] = !lane_act[i];
  end

  sram_rd_capture #(
    .DATA_W (DATA_W),
    .LANES  (LANES)
  ) u_cap (
    .clk      (clk),
    .rst      (rst),
    .cap_en   (cap_en),
    .cap_be   (cap_be),
    .dq_in    (mem_dq_in),
    .rd_valid (rsp_valid),
    .rd_data  (rsp_rdata)
  );

  a_r7_strobe_needs_cs: assert property (@(posedge clk) disable iff (rst)
    (mem_bs_n != '1) |-> !mem_cs_n);

endmodule

// File: tb/sram_lane_ctrl_bench.sv
module sram_lane_ctrl_bench;

  localparam int RD_N = 11;
  localparam int WR_N = 9;
  localparam int HZ_N = 4;
  localparam int TW_N = 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [15:0] mem_addr;
  logic        mem_cs_n, mem_oe_n, mem_we_n;
  logic [1:0]  mem_bs_n;
  logic [15:0] mem_dq_out;
  logic        mem_dq_oe;
  logic [15:0] mem_dq_in;

  always #2.5 clk = ~clk;

  sram_lane_ctrl u_sram_lane_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_bs_n(mem_bs_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // Memory model: 256 words, data valid only after a full access window.
  logic [15:0] mem [256];
  logic [15:0] ref_mem [256];
  int          rcnt = 0;
  bit          clash = 0;
  logic        rd_act;

  assign rd_act = !mem_cs_n && !mem_oe_n && mem_we_n;

  always @(negedge clk) begin
    if (!mem_cs_n && !mem_we_n && mem_dq_oe) begin
      if (!mem_bs_n[0]) mem[mem_addr[7:0]][7:0]  <= mem_dq_out[7:0];
      if (!mem_bs_n[1]) mem[mem_addr[7:0]][15:8] <= mem_dq_out[15:8];
    end
    if (rd_act && mem_dq_oe) clash <= 1'b1;
    rcnt <= rd_act ? rcnt + 1 : 0;
  end

  always_comb begin
    mem_dq_in = 16'hC3C3;
    if (rd_act && rcnt >= RD_N) begin
      if (!mem_bs_n[0]) mem_dq_in[7:0]  = mem[mem_addr[7:0]][7:0];
      if (!mem_bs_n[1]) mem_dq_in[15:8] = mem[mem_addr[7:0]][15:8];
    end
  end

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] lane_mask(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic access(input bit wr, input logic [7:0] a, input logic [15:0] d,
                        input logic [1:0] be);
    int  cyc;
    bit  pins_ok;
    logic [15:0] exp;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = {8'h00, a};
    req_wdata = d;    req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    pins_ok = 1'b1;
    for (int i = 0; i < (wr ? WR_N : RD_N); i++) begin
      if (mem_cs_n !== 1'b0 || mem_we_n !== !wr || mem_oe_n !== wr ||
          mem_bs_n !== ~be || mem_addr !== {8'h00, a} || mem_dq_oe !== wr ||
          req_ready !== 1'b0 || (wr && mem_dq_out !== d))
        pins_ok = 1'b0;
      if (i < (wr ? WR_N : RD_N) - 1) @(negedge clk);
    end
    if (wr) chk(pins_ok, "R5/R7", "write window pins", {31'd0, pins_ok}, 32'd1);
    else    chk(pins_ok, "R3/R7", "read window pins",  {31'd0, pins_ok}, 32'd1);
    @(negedge clk);
    if (wr) begin
      chk(mem_we_n && mem_cs_n && mem_bs_n == 2'b11 && mem_dq_oe &&
          mem_addr == {8'h00, a} && mem_dq_out == d,
          "R6", "hold cycle", {15'd0, mem_dq_oe, mem_dq_out}, {15'd0, 1'b1, d});
      ref_mem[a] = (ref_mem[a] & ~lane_mask(be)) | (d & lane_mask(be));
    end else begin
      exp = ref_mem[a] & lane_mask(be);
      chk(rsp_valid === 1'b1 && rsp_rdata === exp, "R4/R10", "read data",
          {15'd0, rsp_valid, rsp_rdata}, {15'd0, 1'b1, exp});
    end
    @(negedge clk);
    cyc = (wr ? WR_N : RD_N) + 1;
    if (wr) chk(!mem_dq_oe, "R9", "drive released", {31'd0, mem_dq_oe}, 32'd0);
    else    chk(!rsp_valid, "R4", "valid one cycle", {31'd0, rsp_valid}, 32'd0);
    while (!req_ready && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    if (wr) chk(cyc == WR_N + 1 + TW_N, "R9", "write to ready cycles", cyc, WR_N + 1 + TW_N);
    else    chk(cyc == RD_N + HZ_N, "R8", "read to ready cycles", cyc, RD_N + HZ_N);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) begin
      mem[i] = '0;
      ref_mem[i] = '0;
    end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && mem_cs_n && mem_oe_n && mem_we_n && mem_bs_n == 2'b11 &&
        !mem_dq_oe && !rsp_valid, "R1", "reset state",
        {25'd0, req_ready, mem_cs_n, mem_oe_n, mem_we_n, mem_bs_n, mem_dq_oe}, 32'h7E);

    // Directed corner cases
    access(1'b1, 8'h05, 16'h1234, 2'b11);   // R5 full word
    access(1'b0, 8'h05, 16'h0000, 2'b11);   // R3 read right after write
    access(1'b1, 8'h05, 16'hABCD, 2'b10);   // R7 upper lane only
    access(1'b0, 8'h05, 16'h0000, 2'b01);   // R10 lower lane read
    access(1'b0, 8'h05, 16'h0000, 2'b10);   // R10 upper lane read
    access(1'b1, 8'h05, 16'hFFFF, 2'b00);   // R10 no lane written
    access(1'b0, 8'h05, 16'h0000, 2'b11);   // R7 expect AB34
    access(1'b0, 8'h05, 16'h0000, 2'b00);   // R10 reads zero
    access(1'b0, 8'h09, 16'h0000, 2'b11);   // R2 read then read

    // Random mix
    for (int i = 0; i < 120; i++) begin
      access(1'($urandom), 8'($urandom % 16), 16'($urandom), 2'($urandom));
    end

    chk(!clash, "R8", "no bus contention", {31'd0, clash}, 32'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule